// File: doc/BRIEF.md
# SPI Word Shift Engine

This block sends and receives one SPI word at a time as the master of the bus. A requester offers a transmit word along with its shape (bit count, clock phase, idle clock level, select line, and whether transmit and receive are enabled). The engine then drives the serial clock, the outgoing data line and four slave-select lines. It samples the incoming data line and hands back a right-aligned receive word together with a one-cycle completion pulse.

The command side is a valid/ready stream. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low from that edge until the word is finished, so a requester that holds `cmd_valid` just waits, and a pulse on `cmd_valid` during a word is lost. Every configuration input is captured at the accepting edge. The result side has no back-pressure. `rx_valid` is a single-cycle strobe and the consumer must take `rx_word` in that cycle. `rx_word` then holds its value until the next reported word. While the engine is idle, its configuration register follows the inputs with one cycle of delay. This lets the select lines and the clock rest level be set up before a command is issued.

The serial clock half-period is a count of system clocks. Each word ends with one extra half-period before the select line is released.

Top module: `spi_word_engine`

## Requirements
- R1: A word of n bits, where n = `cfg_len_m1` + 1 (1 to 32), produces exactly n clock pulses, which is 2n toggles of `sclk`.
- R2: Only the low n bits of `cmd_word` are sent, most significant of those first. `mosi` is 0 whenever no word is in progress.
- R3: `sclk` rests at the idle level while no word is in progress and returns to it after each word. Codes 1 and 3 of `cfg_idle` give a high level; codes 0 and 2 give a low level.
- R4: With `cfg_phase` = 0, each data bit is on `mosi` before the first toggle of its clock pulse, and `miso` is sampled on that first toggle. With `cfg_phase` = 1, `mosi` changes on the first toggle of each pulse and `miso` is sampled on the second.
- R5: Let D be `cfg_half_div`, with 0 treated as 1. The k-th `sclk` toggle happens at the k·D-th clock edge after the accepting edge.
- R6: With `cfg_tx_en` = 0, `mosi` stays 0 for the whole word.
- R7: The receive word holds the n sampled bits right-aligned, the first sampled bit highest, with bits n and above cleared. With `cfg_rx_en` = 0, `rx_valid` stays low and `rx_word` keeps its previous value.
- R8: `done` is high for exactly the one cycle that follows the (2n+1)·D-th clock edge after acceptance. `rx_valid` is high in that same cycle, and `cmd_ready` returns high in it.
- R9: `cmd_ready` is low from acceptance until the word is finished. A `cmd_valid` pulse or a configuration change during that time has no effect on the word in progress.
- R10: In hardware select mode (`cfg_sel_sw` = 0), the line whose bit is set in the one-hot `cfg_sel_en` is at its active level from acceptance to the end of the word. The active level is low, or high when `cfg_sel_inv` = 1. All other lines sit at the inactive level.
- R11: In software select mode (`cfg_sel_sw` = 1), the enabled line carries the raw value of `cfg_sel_val` and the other lines are inactive. While idle, the select lines reflect new inputs one cycle after they change.
- R12: After reset, `sclk` = 0, `mosi` = 0, `sel` = 4'b1111, `cmd_ready` = 1, `done` = 0, `rx_valid` = 0 and `rx_word` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine can accept a command |
| cmd_word | input | 32 | Transmit word, low n bits used |
| cfg_len_m1 | input | 5 | Bits per word minus one |
| cfg_phase | input | 1 | 0: sample on first toggle of a pulse, 1: on second |
| cfg_idle | input | 2 | Idle clock level code |
| cfg_sel_en | input | 4 | One-hot select line choice |
| cfg_sel_sw | input | 1 | Software select mode |
| cfg_sel_val | input | 1 | Select level in software mode |
| cfg_sel_inv | input | 1 | Active-high select when set |
| cfg_tx_en | input | 1 | Drive data on mosi |
| cfg_rx_en | input | 1 | Report received word |
| cfg_half_div | input | 8 | Clock half-period in system clocks |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| sel | output | 4 | Slave-select lines |
| done | output | 1 | Word finished strobe |
| rx_valid | output | 1 | Receive word strobe |
| rx_word | output | 32 | Received word, right-aligned |

## Verification
Every result is timed from the accepting clock edge. Toggle k of `sclk` is due after k·D edges. `done`, `rx_valid`, `rx_word` and the rise of `cmd_ready` are due after (2n+1)·D edges. Select lines at idle are due one edge after an input change. The bench counts rising edges from acceptance and samples outputs at the following falling edge. Each observation is compared against these arithmetic positions, so a result that comes one cycle early or late fails. A slave model in the bench reacts to the observed clock toggles. It drives `miso` and captures `mosi` with half a cycle of margin on the toggles that R4 assigns for each phase.

// File: rtl/spw_pkg.sv
`timescale 1ns/1ps
package spw_pkg;
  localparam int SPW_WORD_W = 32;
  localparam int SPW_SEL_N  = 4;
  localparam int SPW_DIV_W  = 8;

  typedef enum logic {
    PH_LEAD  = 1'b0,
    PH_TRAIL = 1'b1
  } spw_phase_e;

  function automatic logic spw_idle_level(input logic [1:0] code);
    return (code == 2'd1) || (code == 2'd3);
  endfunction
endpackage

// File: rtl/spw_timer.sv
`timescale 1ns/1ps
module spw_timer #(
  parameter int DIV_W = 8,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIV_W-1:0] div,
  input  logic [CNT_W-1:0] nedges,
  input  logic             idle_lvl,
  output logic             busy,
  output logic             tick,
  output logic             tick_odd,
  output logic             fin,
  output logic             sclk
);
  logic [DIV_W-1:0] hc_q, rl_q, rl_in;
  logic [CNT_W-1:0] ec_q, ne_q;
  logic             busy_q, sclk_q, term;

  assign rl_in    = (div == '0) ? '0 : div - 1'b1;
  assign term     = busy_q && (hc_q == '0);
  assign tick     = term && (ec_q != ne_q);
  assign fin      = term && (ec_q == ne_q);
  assign tick_odd = ~ec_q[0];
  assign busy     = busy_q;
  assign sclk     = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      hc_q   <= '0;
      rl_q   <= '0;
      ec_q   <= '0;
      ne_q   <= '0;
    end else if (!busy_q) begin
      sclk_q <= idle_lvl;
      if (start) begin
        busy_q <= 1'b1;
        hc_q   <= rl_in;
        rl_q   <= rl_in;
        ec_q   <= '0;
        ne_q   <= nedges;
      end
    end else if (hc_q != '0) begin
      hc_q <= hc_q - 1'b1;
    end else begin
      hc_q <= rl_q;
      if (ec_q == ne_q) begin
        busy_q <= 1'b0;
      end else begin
        ec_q   <= ec_q + 1'b1;
        sclk_q <= ~sclk_q;
      end
    end
  end

  p_half_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (rl_q != '0) |=> !tick);
  p_sclk_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !tick |=> $stable(sclk_q));
endmodule

// File: rtl/spw_tx.sv
`timescale 1ns/1ps
module spw_tx
  import spw_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] word,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic              tx_en,
  input  spw_phase_e        phase,
  input  logic              tick,
  input  logic              tick_odd,
  input  logic              fin,
  output logic              mosi
);
  logic [WORD_W-1:0] sh_q;
  logic              drv_q, en_q;
  spw_phase_e        ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      drv_q <= 1'b0;
      en_q  <= 1'b0;
      ph_q  <= PH_LEAD;
    end else if (start) begin
      sh_q  <= word << (WORD_W - 1 - int'(len_m1));
      drv_q <= (phase == PH_LEAD);
      en_q  <= tx_en;
      ph_q  <= phase;
    end else if (fin) begin
      drv_q <= 1'b0;
    end else if (tick) begin
      if (tick_odd) begin
        if (ph_q == PH_TRAIL) begin
          if (!drv_q) drv_q <= 1'b1;
          else        sh_q  <= sh_q << 1;
        end
      end else if (ph_q == PH_LEAD) begin
        sh_q <= sh_q << 1;
      end
    end
  end

  assign mosi = en_q & drv_q & sh_q[WORD_W-1];
endmodule

// File: rtl/spw_rx.sv
`timescale 1ns/1ps
module spw_rx
  import spw_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rx_en,
  input  spw_phase_e        phase,
  input  logic              tick,
  input  logic              tick_odd,
  input  logic              fin,
  input  logic              miso,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_word
);
  logic [WORD_W-1:0] acc_q, data_q;
  logic              en_q, valid_q;
  spw_phase_e        ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      data_q  <= '0;
      en_q    <= 1'b0;
      valid_q <= 1'b0;
      ph_q    <= PH_LEAD;
    end else begin
      valid_q <= fin & en_q;
      if (fin && en_q) data_q <= acc_q;
      if (start) begin
        acc_q <= '0;
        en_q  <= rx_en;
        ph_q  <= phase;
      end else if (tick && (tick_odd == (ph_q == PH_LEAD))) begin
        acc_q <= {acc_q[WORD_W-2:0], miso};
      end
    end
  end

  assign rx_valid = valid_q;
  assign rx_word  = data_q;

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
endmodule

// File: rtl/spw_sel.sv
`timescale 1ns/1ps
module spw_sel #(
  parameter int SEL_N = 4
) (
  input  logic [SEL_N-1:0] en,
  input  logic             sw,
  input  logic             val,
  input  logic             inv,
  input  logic             active,
  output logic [SEL_N-1:0] sel
);
  for (genvar i = 0; i < SEL_N; i++) begin : g_line
    assign sel[i] = !en[i] ? ~inv : (sw ? val : (active ? inv : ~inv));
  end
endmodule

// File: rtl/spi_word_engine.sv
`timescale 1ns/1ps
module spi_word_engine
  import spw_pkg::*;
#(
  parameter int WORD_W = SPW_WORD_W,
  parameter int SEL_N  = SPW_SEL_N,
  parameter int DIV_W  = SPW_DIV_W,
  localparam int LEN_W = $clog2(WORD_W),
  localparam int CNT_W = $clog2(2 * WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic [LEN_W-1:0]  cfg_len_m1,
  input  logic              cfg_phase,
  input  logic [1:0]        cfg_idle,
  input  logic [SEL_N-1:0]  cfg_sel_en,
  input  logic              cfg_sel_sw,
  input  logic              cfg_sel_val,
  input  logic              cfg_sel_inv,
  input  logic              cfg_tx_en,
  input  logic              cfg_rx_en,
  input  logic [DIV_W-1:0]  cfg_half_div,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [SEL_N-1:0]  sel,
  output logic              done,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_word
);
  logic             busy, tick, tick_odd, fin, start, idle_lvl, done_q;
  logic [CNT_W-1:0] nedges;
  spw_phase_e       phase;

  logic [LEN_W-1:0] len_q;
  logic             idle_q, sw_q, val_q, inv_q, txe_q, rxe_q;
  logic [SEL_N-1:0] en_q;

  assign cmd_ready = !busy;
  assign start     = cmd_valid && !busy;
  assign idle_lvl  = spw_idle_level(cfg_idle);
  assign nedges    = CNT_W'((32'(cfg_len_m1) + 1) * 2);
  assign phase     = spw_phase_e'(cfg_phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      idle_q <= 1'b0;
      en_q   <= '0;
      sw_q   <= 1'b0;
      val_q  <= 1'b0;
      inv_q  <= 1'b0;
      txe_q  <= 1'b0;
      rxe_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= fin;
      if (!busy) begin
        len_q  <= cfg_len_m1;
        idle_q <= idle_lvl;
        en_q   <= cfg_sel_en;
        sw_q   <= cfg_sel_sw;
        val_q  <= cfg_sel_val;
        inv_q  <= cfg_sel_inv;
        txe_q  <= cfg_tx_en;
        rxe_q  <= cfg_rx_en;
      end
    end
  end

  assign done = done_q;

  spw_timer #(.DIV_W(DIV_W), .CNT_W(CNT_W)) i_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .div(cfg_half_div),
    .nedges(nedges), .idle_lvl(idle_lvl), .busy(busy), .tick(tick),
    .tick_odd(tick_odd), .fin(fin), .sclk(sclk)
  );

  spw_tx #(.WORD_W(WORD_W), .LEN_W(LEN_W)) i_tx (
    .clk(clk), .rst_n(rst_n), .start(start), .word(cmd_word),
    .len_m1(cfg_len_m1), .tx_en(cfg_tx_en), .phase(phase), .tick(tick),
    .tick_odd(tick_odd), .fin(fin), .mosi(mosi)
  );

  spw_rx #(.WORD_W(WORD_W)) i_rx (
    .clk(clk), .rst_n(rst_n), .start(start), .rx_en(cfg_rx_en),
    .phase(phase), .tick(tick), .tick_odd(tick_odd), .fin(fin),
    .miso(miso), .rx_valid(rx_valid), .rx_word(rx_word)
  );

  spw_sel #(.SEL_N(SEL_N)) i_sel (
    .en(en_q), .sw(sw_q), .val(val_q), .inv(inv_q), .active(busy), .sel(sel)
  );

  p_sclk_rest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk == idle_q);
  p_mosi_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mosi);
  p_mosi_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !txe_q |-> !mosi);
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_rx_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> done && rxe_q);
  p_rx_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ((64'(rx_word) >> (32'(len_q) + 1)) == 64'd0));
  p_sel_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(sel));
  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> busy);
endmodule

// File: tb/test_spi_word_engine.sv
`timescale 1ns/1ps
module test_spi_word_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid, cmd_ready;
  logic [31:0] cmd_word;
  logic [4:0]  cfg_len_m1;
  logic        cfg_phase;
  logic [1:0]  cfg_idle;
  logic [3:0]  cfg_sel_en;
  logic        cfg_sel_sw, cfg_sel_val, cfg_sel_inv, cfg_tx_en, cfg_rx_en;
  logic [7:0]  cfg_half_div;
  logic        sclk, mosi, miso, done, rx_valid;
  logic [3:0]  sel;
  logic [31:0] rx_word;

  int          n_run = 0;
  int          n_fail = 0;
  logic [31:0] last_rx = 32'd0;

  always #2.5 clk = ~clk;

  spi_word_engine i_spi_word_engine (.*);

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_word(input logic [31:0] w, input logic [31:0] mw, input bit poke);
    int n, d, edges, done_at, done_cnt, lim;
    logic [31:0] mask, got, rxw;
    logic [3:0]  exp_sel;
    logic [4:0]  keep_len;
    logic        keep_ph, rxv, prev, idle_exp;
    bit          tim_ok, mosi_ok, sel_ok, rdy_ok;
    n = int'(cfg_len_m1) + 1;
    d = (cfg_half_div == 8'd0) ? 1 : int'(cfg_half_div);
    mask = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
    for (int i = 0; i < 4; i++)
      exp_sel[i] = cfg_sel_en[i] ? (cfg_sel_sw ? cfg_sel_val : cfg_sel_inv) : ~cfg_sel_inv;
    idle_exp = (cfg_idle == 2'd1) || (cfg_idle == 2'd3);
    keep_len = cfg_len_m1;
    keep_ph  = cfg_phase;
    lim = (2 * n + 1) * d;
    edges = 0; done_at = -1; done_cnt = 0; got = 32'd0; rxw = 32'd0; rxv = 1'b0;
    tim_ok = 1; mosi_ok = 1; sel_ok = 1; rdy_ok = 1;
    cmd_word = w;
    miso = keep_ph ? 1'b0 : mw[n-1];
    cmd_valid = 1'b1;
    check(cmd_ready === 1'b1, "R9 ready before accept", 32'(cmd_ready), 32'd1);
    @(negedge clk);
    cmd_valid = 1'b0;
    prev = sclk;
    for (int c = 1; c <= lim + 3; c++) begin
      @(negedge clk);
      if (sclk !== prev) begin
        edges++;
        prev = sclk;
        if (c != edges * d) tim_ok = 0;
        if (edges % 2 == 1) begin
          if (!keep_ph) got = {got[30:0], mosi};
          else if ((edges - 1) / 2 < n) miso = mw[n - 1 - (edges - 1) / 2];
        end else begin
          if (keep_ph) got = {got[30:0], mosi};
          else if (edges / 2 < n) miso = mw[n - 1 - edges / 2];
        end
      end
      if (!cfg_tx_en && mosi !== 1'b0) mosi_ok = 0;
      if (c < lim) begin
        if (sel !== exp_sel) sel_ok = 0;
        if (cmd_ready !== 1'b0) rdy_ok = 0;
      end
      if (done === 1'b1) begin
        done_cnt++;
        if (done_at < 0) done_at = c;
      end
      if (c == lim) begin
        rxv = rx_valid;
        rxw = rx_word;
        if (cmd_ready !== 1'b1) rdy_ok = 0;
      end
      if (poke && c == 1) begin
        cmd_valid = 1'b1; cmd_word = ~w; cfg_len_m1 = ~keep_len; cfg_phase = ~keep_ph;
      end
      if (poke && c == 2) begin
        cmd_valid = 1'b0; cmd_word = w; cfg_len_m1 = keep_len; cfg_phase = keep_ph;
      end
    end
    check(edges == 2 * n, "R1 sclk toggle count", 32'(edges), 32'(2 * n));
    check(tim_ok, "R5 toggle spacing", 32'(tim_ok), 32'd1);
    if (cfg_tx_en)
      check((got & mask) == (w & mask), "R2 R4 mosi bit order", got & mask, w & mask);
    else
      check(mosi_ok, "R6 mosi held low", 32'(mosi_ok), 32'd1);
    check(done_at == lim && done_cnt == 1, "R8 done cycle", 32'(done_at), 32'(lim));
    if (cfg_rx_en) begin
      check(rxv === 1'b1 && rxw == (mw & mask), "R7 rx word", rxw, mw & mask);
      last_rx = mw & mask;
    end else begin
      check(rxv === 1'b0 && rx_word == last_rx, "R7 rx disabled", rx_word, last_rx);
    end
    check(sel_ok, cfg_sel_sw ? "R11 software select" : "R10 hardware select",
          32'(sel), 32'(exp_sel));
    check(sclk === idle_exp, "R3 idle clock level", 32'(sclk), 32'(idle_exp));
    if (poke) check(rdy_ok, "R9 start ignored while busy", 32'(rdy_ok), 32'd1);
  endtask

  initial begin
    #(200000 * 5.0);
    n_run++;
    n_fail++;
    $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    cmd_valid = 0; cmd_word = 0; cfg_len_m1 = 0; cfg_phase = 0; cfg_idle = 0;
    cfg_sel_en = 0; cfg_sel_sw = 0; cfg_sel_val = 0; cfg_sel_inv = 0;
    cfg_tx_en = 1; cfg_rx_en = 1; cfg_half_div = 1; miso = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    check(sclk === 1'b0 && mosi === 1'b0, "R12 reset clock and data", {30'd0, sclk, mosi}, 32'd0);
    check(sel === 4'hF, "R12 reset select", 32'(sel), 32'hF);
    check(cmd_ready === 1'b1 && done === 1'b0 && rx_valid === 1'b0,
          "R12 reset handshake", {29'd0, cmd_ready, done, rx_valid}, 32'd4);
    check(rx_word === 32'd0, "R12 reset rx word", rx_word, 32'd0);

    // sweep: idle code x phase x length, divider 0..3
    for (int ic = 0; ic < 4; ic++) begin
      for (int ph = 0; ph < 2; ph++) begin
        for (int ln = 0; ln < 32; ln++) begin
          cfg_idle = 2'(ic); cfg_phase = ph[0]; cfg_len_m1 = 5'(ln);
          cfg_half_div = 8'(ln % 4); cfg_sel_en = 4'd1 << (ln % 4);
          cfg_sel_inv = ((ln / 4) % 2) == 1; cfg_sel_sw = 0;
          cfg_tx_en = 1; cfg_rx_en = 1;
          @(negedge clk);
          run_word(32'h9E37_79B9 * 32'(ln + 1) + 32'(ic * 7 + ph),
                   (32'hC2B2_AE35 * 32'(ln + 3)) ^ 32'(ic * 5 + ph * 11),
                   (ln % 8) == 5);
        end
      end
    end

    // R6 transmit disabled
    cfg_idle = 2'd1; cfg_phase = 1; cfg_len_m1 = 5'd12; cfg_half_div = 8'd2;
    cfg_sel_en = 4'b0010; cfg_tx_en = 0; cfg_rx_en = 1;
    @(negedge clk);
    run_word(32'hFFFF_FFFF, 32'h0000_1A5B, 1'b0);

    // R7 receive disabled, rx_word must keep previous value
    cfg_tx_en = 1; cfg_rx_en = 0; cfg_half_div = 8'd5; cfg_len_m1 = 5'd6;
    @(negedge clk);
    run_word(32'h0000_0055, 32'h0000_007F, 1'b0);

    // R11 software select during a word
    cfg_rx_en = 1; cfg_sel_sw = 1; cfg_sel_val = 1; cfg_sel_inv = 0; cfg_sel_en = 4'b1000;
    cfg_half_div = 8'd1; cfg_len_m1 = 5'd31; cfg_phase = 0; cfg_idle = 2'd2;
    @(negedge clk);
    run_word(32'h8000_0001, 32'h1234_5678, 1'b1);

    // R11 idle select follows inputs one cycle later
    cfg_sel_sw = 1; cfg_sel_val = 0; cfg_sel_inv = 0; cfg_sel_en = 4'b0100;
    @(negedge clk);
    check(sel === 4'b1011, "R11 idle software select low", 32'(sel), 32'hB);
    cfg_sel_val = 1; cfg_sel_inv = 1; cfg_sel_en = 4'b0001;
    @(negedge clk);
    check(sel === 4'b0001, "R11 idle software select inverted", 32'(sel), 32'h1);
    cfg_sel_sw = 0; cfg_sel_inv = 0; cfg_sel_en = 4'b0001;
    @(negedge clk);
    check(sel === 4'b1111, "R10 idle hardware select inactive", 32'(sel), 32'hF);
    cfg_idle = 2'd3;
    @(negedge clk);
    check(sclk === 1'b1, "R3 idle level follows code 3", 32'(sclk), 32'd1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule